// File: doc/BRIEF.md
# Alarm-Started Periodic Pulse Generator

This block turns a free-running 64-bit time value into timed output events. It holds two 64-bit alarm registers that are compared against the time input. Each alarm fires once when the time reaches it, and it can drive an output pulse. The block also has three periodic pulse channels. Each channel counts down a programmable interval, and each time the count expires it emits a pulse of programmable width.

The pulse widths are given in periods of a slow output clock. That clock is the timer clock divided by an even prescaler. A start-synchronised mode holds every channel counter until the first alarm matches, so a pulse train can be started at an exact time. Alarm and channel events are latched into a sticky event register that is cleared by writing ones. A mask register gates the events onto one interrupt line.

Software reaches the block through a plain word-addressed write strobe and a combinational read port. The time counter lives outside the block and is fed in on `time_i`.

Top module: `alarm_pulse_gen`

## Requirements
- R1: After reset the block is in a defined state. The event, mask, control and alarm-control words read 0. The channel-control word reads 0x00808080, so all channels are disabled. Every interval reads 0xFFFFFFFF. Both alarms read all ones, which means disarmed. The prescaler reads 2. All outputs are low.
- R2: A write to the prescaler (address 3) clears bit 0 of the written value. If the result is zero, the prescaler is stored as 2. Only the low 16 bits are kept.
- R3: Each alarm is written as a low word and then a high word. Alarm 1 uses addresses 4 and 5. Alarm 2 uses addresses 6 and 7. The write to the high word commits both halves together. A write to the low word alone changes neither the compared value nor the value read back.
- R4: An armed alarm fires once, in the cycle where the time input is greater than or equal to its value. An alarm is armed when its value is not all ones. A fired alarm does not fire again until its high word is written. Alarm 1 sets event bit 16 and alarm 2 sets event bit 17.
- R5: The alarm-control word (address 8) holds one byte per alarm: width in bits 4:0 and pulse select in bit 7. With pulse select set, the alarm output is high for width × prescaler clock cycles, starting in the cycle after the match. With pulse select clear, it is high for one cycle. Control bit 31 inverts the alarm 1 output.
- R6: An enabled channel with interval I emits its first pulse I+1 cycles after the enabling write. After that it emits one pulse every I+1 cycles. Channel intervals are at addresses 9, 10 and 11.
- R7: The channel-control word (address 12) holds byte n for channel n: width in bits 4:0, pulse select in bit 6, disable in bit 7. With pulse select set, a channel pulse lasts width × prescaler cycles. With pulse select clear, it lasts one cycle.
- R8: A disabled channel keeps its output low, sets no event, and reloads its counter from the interval.
- R9: While control bit 28 is set, the channel counters hold until alarm 1 matches, and then they run. A match on alarm 2 does not release them.
- R10: Channels 0, 1 and 2 set event bits 7, 6 and 5. Event bits stay set until a one is written to that bit of the event word (address 1). If a set and a clear happen in the same cycle, the set wins.
- R11: The interrupt output is high exactly when some event bit is set and its bit in the mask word (address 2) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_i | input | 64 | Current time value |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write word address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 4 | Register read word address |
| rd_data_o | output | 32 | Register read data (combinational) |
| pulse_o | output | 3 | Periodic channel pulse outputs |
| alarm_o | output | 2 | Alarm outputs |
| irq_o | output | 1 | Masked event interrupt |

## Verification
A wrong counter load or decrement in a channel moves the pulse edges. This shows as a first rise, a period or a pulse length that is off by at least one cycle within the first two periods. The bench measures all three edges for every channel over a sweep of intervals, widths, prescalers and pulse modes. A lost or doubled alarm fire shows at once as a wrong event word or a wrong alarm-output length. A start-sync gate that opens early shows as a pulse while the counters should still be held. Event-clear or mask faults show in the very next cycle on the interrupt line.

// File: rtl/apg_pkg.sv
package apg_pkg;
  localparam int unsigned REG_AW  = 4;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned PW_W    = 5;
  localparam int unsigned NUM_AL  = 2;

  localparam logic [REG_AW-1:0] A_CTRL   = 4'd0;
  localparam logic [REG_AW-1:0] A_EVENT  = 4'd1;
  localparam logic [REG_AW-1:0] A_MASK   = 4'd2;
  localparam logic [REG_AW-1:0] A_PRSC   = 4'd3;
  localparam logic [REG_AW-1:0] A_AL_LO0 = 4'd4;
  localparam logic [REG_AW-1:0] A_ALCTL  = 4'd8;
  localparam logic [REG_AW-1:0] A_IVL0   = 4'd9;
  localparam logic [REG_AW-1:0] A_CHCTL  = 4'd12;

  localparam int unsigned CTRL_FS_BIT  = 28;
  localparam int unsigned CTRL_POL_BIT = 31;
  localparam int unsigned EV_CH_TOP    = 7;
  localparam int unsigned EV_AL_BASE   = 16;

  typedef struct packed {
    logic            dis;
    logic            pg;
    logic [PW_W-1:0] width;
  } ch_cfg_t;

  typedef struct packed {
    logic            pg;
    logic [PW_W-1:0] width;
  } al_cfg_t;
endpackage

// File: rtl/apg_stretch.sv
module apg_stretch import apg_pkg::*; #(
  parameter int unsigned PRSC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic              pg_i,
  input  logic [PW_W-1:0]   width_i,
  input  logic [PRSC_W-1:0] prsc_i,
  output logic              level_o
);
  localparam int unsigned CW = PW_W + PRSC_W;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (start_i) begin
      cnt_d = pg_i ? (CW'(width_i) * CW'(prsc_i)) : CW'(1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign level_o = (cnt_q != '0);

  // R7
  dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !start_i && !clr_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/apg_alarm.sv
module apg_alarm import apg_pkg::*; #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned PRSC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [TIME_W/2-1:0] wr_data_i,
  input  logic              pg_i,
  input  logic [PW_W-1:0]   width_i,
  input  logic [PRSC_W-1:0] prsc_i,
  input  logic              pol_i,
  output logic              hit_o,
  output logic              level_o,
  output logic [TIME_W-1:0] value_o
);
  localparam int unsigned HALF_W = TIME_W / 2;

  logic [HALF_W-1:0] stage_q, stage_d;
  logic [TIME_W-1:0] value_q, value_d;
  logic              fired_q, fired_d;
  logic              armed, hit, lvl;

  assign armed = (value_q != '1);
  assign hit   = armed && !fired_q && (time_i >= value_q) && !wr_hi_i;

  always_comb begin
    stage_d = stage_q;
    value_d = value_q;
    fired_d = fired_q;
    if (wr_lo_i) stage_d = wr_data_i;
    if (wr_hi_i) begin
      value_d = {wr_data_i, stage_q};
      fired_d = 1'b0;
    end else if (hit) begin
      fired_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '1;
      value_q <= '1;
      fired_q <= 1'b0;
    end else begin
      stage_q <= stage_d;
      value_q <= value_d;
      fired_q <= fired_d;
    end
  end

  apg_stretch #(.PRSC_W(PRSC_W)) i_stretch (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (1'b0),
    .start_i (hit),
    .pg_i    (pg_i),
    .width_i (width_i),
    .prsc_i  (prsc_i),
    .level_o (lvl)
  );

  assign hit_o   = hit;
  assign level_o = lvl ^ pol_i;
  assign value_o = value_q;

  // R4
  fire_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_q && !wr_hi_i) |=> fired_q);

  // R4
  fire_ge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fired_q) |-> $past(time_i >= value_q));
endmodule

// File: rtl/apg_channel.sv
module apg_channel import apg_pkg::*; #(
  parameter int unsigned IVL_W  = 32,
  parameter int unsigned PRSC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  ch_cfg_t           cfg_i,
  input  logic [IVL_W-1:0]  interval_i,
  input  logic [PRSC_W-1:0] prsc_i,
  output logic              fire_o,
  output logic              pulse_o
);
  logic [IVL_W-1:0] cnt_q, cnt_d;
  logic             fire, lvl;

  assign fire = !cfg_i.dis && run_i && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (cfg_i.dis) begin
      cnt_d = interval_i;
    end else if (run_i) begin
      cnt_d = (cnt_q == '0) ? interval_i : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end

  apg_stretch #(.PRSC_W(PRSC_W)) i_stretch (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (cfg_i.dis),
    .start_i (fire),
    .pg_i    (cfg_i.pg),
    .width_i (cfg_i.width),
    .prsc_i  (prsc_i),
    .level_o (lvl)
  );

  assign fire_o  = fire;
  assign pulse_o = lvl && !cfg_i.dis;

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_i.dis && !run_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/apg_regs.sv
module apg_regs import apg_pkg::*; #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned TIME_W = 64,
  parameter int unsigned IVL_W  = 32,
  parameter int unsigned PRSC_W = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en_i,
  input  logic [REG_AW-1:0]              wr_addr_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  input  logic [REG_AW-1:0]              rd_addr_i,
  output logic [DATA_W-1:0]              rd_data_o,
  input  logic [NUM_AL-1:0][TIME_W-1:0]  al_val_i,
  input  logic [DATA_W-1:0]              ev_set_i,
  output logic                           fs_o,
  output logic                           pol_o,
  output logic [PRSC_W-1:0]              prsc_o,
  output al_cfg_t [NUM_AL-1:0]           al_cfg_o,
  output ch_cfg_t [NUM_CH-1:0]           ch_cfg_o,
  output logic [NUM_CH-1:0][IVL_W-1:0]   ivl_o,
  output logic                           irq_o
);
  localparam int unsigned HALF_W = TIME_W / 2;

  logic                         fs_q, fs_d, pol_q, pol_d;
  logic [DATA_W-1:0]            ev_q, ev_d, ev_clr, mask_q, mask_d;
  logic [PRSC_W-1:0]            prsc_q, prsc_d, prsc_w;
  al_cfg_t [NUM_AL-1:0]         al_q, al_d;
  ch_cfg_t [NUM_CH-1:0]         ch_q, ch_d;
  logic [NUM_CH-1:0][IVL_W-1:0] ivl_q, ivl_d;

  always_comb begin
    prsc_w = wr_data_i[PRSC_W-1:0] & ~PRSC_W'(1);
    if (prsc_w == '0) prsc_w = PRSC_W'(2);
  end

  always_comb begin
    fs_d   = fs_q;
    pol_d  = pol_q;
    mask_d = mask_q;
    prsc_d = prsc_q;
    al_d   = al_q;
    ch_d   = ch_q;
    ivl_d  = ivl_q;
    ev_clr = '0;
    if (wr_en_i) begin
      case (wr_addr_i)
        A_CTRL: begin
          fs_d  = wr_data_i[CTRL_FS_BIT];
          pol_d = wr_data_i[CTRL_POL_BIT];
        end
        A_EVENT: ev_clr = wr_data_i;
        A_MASK:  mask_d = wr_data_i;
        A_PRSC:  prsc_d = prsc_w;
        A_ALCTL: begin
          for (int a = 0; a < NUM_AL; a++) begin
            al_d[a].pg    = wr_data_i[8*a+7];
            al_d[a].width = wr_data_i[8*a +: PW_W];
          end
        end
        A_CHCTL: begin
          for (int c = 0; c < NUM_CH; c++) begin
            ch_d[c].dis   = wr_data_i[8*c+7];
            ch_d[c].pg    = wr_data_i[8*c+6];
            ch_d[c].width = wr_data_i[8*c +: PW_W];
          end
        end
        default: ;
      endcase
      for (int c = 0; c < NUM_CH; c++) begin
        if (wr_addr_i == A_IVL0 + REG_AW'(c)) ivl_d[c] = wr_data_i[IVL_W-1:0];
      end
    end
    ev_d = (ev_q & ~ev_clr) | ev_set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= 1'b0;
      pol_q  <= 1'b0;
      ev_q   <= '0;
      mask_q <= '0;
      prsc_q <= PRSC_W'(2);
      al_q   <= '0;
      for (int c = 0; c < NUM_CH; c++) ch_q[c] <= '{dis: 1'b1, pg: 1'b0, width: '0};
      ivl_q  <= '1;
    end else begin
      fs_q   <= fs_d;
      pol_q  <= pol_d;
      ev_q   <= ev_d;
      mask_q <= mask_d;
      prsc_q <= prsc_d;
      al_q   <= al_d;
      ch_q   <= ch_d;
      ivl_q  <= ivl_d;
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_CTRL: begin
        rd_data_o[CTRL_FS_BIT]  = fs_q;
        rd_data_o[CTRL_POL_BIT] = pol_q;
      end
      A_EVENT: rd_data_o = ev_q;
      A_MASK:  rd_data_o = mask_q;
      A_PRSC:  rd_data_o = DATA_W'(prsc_q);
      A_ALCTL: begin
        for (int a = 0; a < NUM_AL; a++) begin
          rd_data_o[8*a+7]       = al_q[a].pg;
          rd_data_o[8*a +: PW_W] = al_q[a].width;
        end
      end
      A_CHCTL: begin
        for (int c = 0; c < NUM_CH; c++) begin
          rd_data_o[8*c+7]       = ch_q[c].dis;
          rd_data_o[8*c+6]       = ch_q[c].pg;
          rd_data_o[8*c +: PW_W] = ch_q[c].width;
        end
      end
      default: ;
    endcase
    for (int a = 0; a < NUM_AL; a++) begin
      if (rd_addr_i == A_AL_LO0 + REG_AW'(2*a))   rd_data_o = DATA_W'(al_val_i[a][HALF_W-1:0]);
      if (rd_addr_i == A_AL_LO0 + REG_AW'(2*a+1)) rd_data_o = DATA_W'(al_val_i[a][TIME_W-1:HALF_W]);
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_addr_i == A_IVL0 + REG_AW'(c)) rd_data_o = DATA_W'(ivl_q[c]);
    end
  end

  assign fs_o     = fs_q;
  assign pol_o    = pol_q;
  assign prsc_o   = prsc_q;
  assign al_cfg_o = al_q;
  assign ch_cfg_o = ch_q;
  assign ivl_o    = ivl_q;
  assign irq_o    = |(ev_q & mask_q);

  // R10
  ev_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && wr_addr_i == A_EVENT) |=> (($past(ev_q) & ~ev_q) == '0));
endmodule

// File: rtl/alarm_pulse_gen.sv
module alarm_pulse_gen import apg_pkg::*; #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned TIME_W = 64,
  parameter int unsigned IVL_W  = 32,
  parameter int unsigned PRSC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_i,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [NUM_CH-1:0] pulse_o,
  output logic [NUM_AL-1:0] alarm_o,
  output logic              irq_o
);
  logic                         fs, pol;
  logic [PRSC_W-1:0]            prsc;
  al_cfg_t [NUM_AL-1:0]         al_cfg;
  ch_cfg_t [NUM_CH-1:0]         ch_cfg;
  logic [NUM_CH-1:0][IVL_W-1:0] ivl;
  logic [NUM_AL-1:0][TIME_W-1:0] al_val;
  logic [NUM_AL-1:0]            al_hit;
  logic [NUM_CH-1:0]            ch_fire;
  logic [DATA_W-1:0]            ev_set;
  logic                         started_q, started_d, run;

  apg_regs #(.NUM_CH(NUM_CH), .TIME_W(TIME_W), .IVL_W(IVL_W), .PRSC_W(PRSC_W)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .al_val_i  (al_val),
    .ev_set_i  (ev_set),
    .fs_o      (fs),
    .pol_o     (pol),
    .prsc_o    (prsc),
    .al_cfg_o  (al_cfg),
    .ch_cfg_o  (ch_cfg),
    .ivl_o     (ivl),
    .irq_o     (irq_o)
  );

  always_comb begin
    started_d = started_q;
    if (!fs)            started_d = 1'b0;
    else if (al_hit[0]) started_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started_q <= 1'b0;
    else        started_q <= started_d;
  end

  assign run = !fs || started_q;

  for (genvar a = 0; a < NUM_AL; a++) begin : g_alarm
    logic wr_lo, wr_hi;
    assign wr_lo = wr_en_i && (wr_addr_i == A_AL_LO0 + REG_AW'(2*a));
    assign wr_hi = wr_en_i && (wr_addr_i == A_AL_LO0 + REG_AW'(2*a+1));
    apg_alarm #(.TIME_W(TIME_W), .PRSC_W(PRSC_W)) i_alarm (
      .clk       (clk),
      .rst_n     (rst_n),
      .time_i    (time_i),
      .wr_lo_i   (wr_lo),
      .wr_hi_i   (wr_hi),
      .wr_data_i (wr_data_i[TIME_W/2-1:0]),
      .pg_i      (al_cfg[a].pg),
      .width_i   (al_cfg[a].width),
      .prsc_i    (prsc),
      .pol_i     ((a == 0) ? pol : 1'b0),
      .hit_o     (al_hit[a]),
      .level_o   (alarm_o[a]),
      .value_o   (al_val[a])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    apg_channel #(.IVL_W(IVL_W), .PRSC_W(PRSC_W)) i_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (run),
      .cfg_i      (ch_cfg[c]),
      .interval_i (ivl[c]),
      .prsc_i     (prsc),
      .fire_o     (ch_fire[c]),
      .pulse_o    (pulse_o[c])
    );
  end

  always_comb begin
    ev_set = '0;
    for (int c = 0; c < NUM_CH; c++) ev_set[EV_CH_TOP-c] = ch_fire[c];
    for (int a = 0; a < NUM_AL; a++) ev_set[EV_AL_BASE+a] = al_hit[a];
  end
endmodule

// File: tb/test_alarm_pulse_gen.sv
module test_alarm_pulse_gen;
  import apg_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] time_i;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  rd_addr;
  logic [31:0] rd_data;
  logic [2:0]  pulse_o;
  logic [1:0]  alarm_o;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  int first_k[5];
  int len_k[5];
  int second_k[5];

  always #5 clk = ~clk;

  alarm_pulse_gen i_alarm_pulse_gen (
    .clk(clk), .rst_n(rst_n), .time_i(time_i),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .pulse_o(pulse_o), .alarm_o(alarm_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic meas(input int maxk);
    logic [4:0] prev, cur;
    for (int b = 0; b < 5; b++) begin
      first_k[b] = -1; len_k[b] = -1; second_k[b] = -1;
    end
    prev = '0;
    for (int k = 0; k <= maxk; k++) begin
      cur = {alarm_o, pulse_o};
      for (int b = 0; b < 5; b++) begin
        if (cur[b] && !prev[b]) begin
          if (first_k[b] < 0) first_k[b] = k;
          else if (second_k[b] < 0) second_k[b] = k;
        end
        if (!cur[b] && prev[b] && len_k[b] < 0) len_k[b] = k - first_k[b];
      end
      prev = cur;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [15:0] ep;
    int ok;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; time_i = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(A_EVENT, r);  chk("R1 event", r, 0);
    rd(A_MASK, r);   chk("R1 mask", r, 0);
    rd(A_CTRL, r);   chk("R1 ctrl", r, 0);
    rd(A_ALCTL, r);  chk("R1 alctl", r, 0);
    rd(A_CHCTL, r);  chk("R1 chctl", r, 32'h0080_8080);
    rd(A_PRSC, r);   chk("R1 prsc", r, 2);
    for (int c = 0; c < 3; c++) begin
      rd(A_IVL0 + 4'(c), r); chk("R1 interval", r, 32'hFFFF_FFFF);
    end
    for (int a = 4; a < 8; a++) begin
      rd(4'(a), r); chk("R1 alarm word", r, 32'hFFFF_FFFF);
    end
    chk("R1 outputs", {irq_o, alarm_o, pulse_o}, 0);

    // R8 disabled channel stays quiet
    wr(A_IVL0 + 4'd1, 2);
    ok = 1;
    for (int k = 0; k < 30; k++) begin
      if (pulse_o != 0) ok = 0;
      @(negedge clk);
    end
    chk("R8 disabled output low", ok, 1);
    rd(A_EVENT, r); chk("R8 no event", r, 0);

    // R2 prescaler forcing
    for (int v = 0; v < 12; v++) begin
      logic [31:0] wv;
      wv = (v < 10) ? 32'(v) : ((v == 10) ? 32'h0000_FFFF : 32'h0001_0003);
      ep = wv[15:0] & 16'hFFFE;
      if (ep == 0) ep = 2;
      wr(A_PRSC, wv);
      rd(A_PRSC, r);
      chk("R2 prescaler", r, 32'(ep));
    end

    // R6 R7 R10 R11 channel sweep
    for (int ch = 0; ch < 3; ch++)
      for (int ii = 0; ii < 2; ii++)
        for (int w = 1; w <= 2; w++)
          for (int pg = 0; pg < 2; pg++)
            for (int pi = 0; pi < 2; pi++) begin
              int iv, p, elen;
              logic [31:0] cc;
              iv = (ii == 0) ? 4 : 9;
              p = (pi == 0) ? 2 : 4;
              elen = pg ? w * p : 1;
              if (elen < iv + 1) begin
                cc = 32'h0080_8080;
                cc[8*ch +: 8] = {1'b0, 1'(pg), 1'b0, 5'(w)};
                wr(A_PRSC, 32'(p));
                wr(A_IVL0 + 4'(ch), 32'(iv));
                wr(A_CHCTL, cc);
                meas(2 * iv + 4);
                chk("R6 first pulse", 64'(first_k[ch]), 64'(iv + 1));
                chk("R6 period", 64'(second_k[ch]), 64'(2 * iv + 2));
                chk("R7 width", 64'(len_k[ch]), 64'(elen));
                wr(A_CHCTL, 32'h0080_8080);
                rd(A_EVENT, r);
                chk("R10 channel event bit", r, 32'(1) << (7 - ch));
                chk("R11 unmasked irq low", irq_o, 0);
                wr(A_MASK, 32'(1) << (7 - ch));
                chk("R11 masked irq high", irq_o, 1);
                wr(A_MASK, 32'(1) << 16);
                chk("R11 other mask irq low", irq_o, 0);
                wr(A_EVENT, 32'(1) << (7 - ch));
                rd(A_EVENT, r);
                chk("R10 w1c clears", r, 0);
                wr(A_MASK, 0);
              end
            end

    // R3 R4 R5 alarms
    wr(A_PRSC, 2);
    wr(A_ALCTL, 32'h0000_0182);
    time_i = 64'd600;
    wr(A_AL_LO0, 500);
    idle(3);
    rd(A_EVENT, r); chk("R3 low word alone no fire", r, 0);
    rd(A_AL_LO0, r); chk("R3 low word not committed", r, 32'hFFFF_FFFF);
    time_i = 64'd499;
    wr(A_AL_LO0 + 4'd1, 0);
    idle(3);
    rd(A_EVENT, r); chk("R4 below value no fire", r, 0);
    rd(A_AL_LO0, r); chk("R3 committed low", r, 500);
    @(negedge clk); time_i = 64'd500;
    @(negedge clk);
    meas(10);
    chk("R5 alarm1 pulse start", 64'(first_k[3]), 0);
    chk("R5 alarm1 pulse width", 64'(len_k[3]), 4);
    rd(A_EVENT, r); chk("R4 alarm1 event", r, 32'h0001_0000);
    wr(A_EVENT, 32'hFFFF_FFFF);
    time_i = 64'd5000;
    idle(5);
    rd(A_EVENT, r); chk("R4 fires once", r, 0);
    wr(A_AL_LO0, 32'hFFFF_FFFF);
    wr(A_AL_LO0 + 4'd1, 32'hFFFF_FFFF);
    time_i = 64'hFFFF_FFFF_FFFF_FFFF;
    idle(3);
    wr(A_EVENT, 32'hFFFF_FFFF);
    idle(3);
    rd(A_EVENT, r); chk("R4 all ones disarmed", r, 0);
    time_i = 64'd0;
    wr(A_AL_LO0 + 4'd2, 50);
    wr(A_AL_LO0 + 4'd3, 0);
    @(negedge clk); time_i = 64'd60;
    @(negedge clk);
    meas(5);
    chk("R5 alarm2 strobe start", 64'(first_k[4]), 0);
    chk("R5 alarm2 strobe width", 64'(len_k[4]), 1);
    rd(A_EVENT, r); chk("R4 alarm2 event", r, 32'h0002_0000);
    wr(A_EVENT, 32'hFFFF_FFFF);

    // R5 alarm1 polarity
    wr(A_CTRL, 32'h8000_0000);
    chk("R5 inverted idle high", alarm_o[0], 1);
    time_i = 64'd0;
    wr(A_AL_LO0, 100);
    wr(A_AL_LO0 + 4'd1, 0);
    @(negedge clk); time_i = 64'd100;
    @(negedge clk);
    chk("R5 inverted pulse low", alarm_o[0], 0);
    ok = 0;
    for (int k = 0; k < 10; k++) begin
      if (!alarm_o[0]) ok++;
      @(negedge clk);
    end
    chk("R5 inverted pulse length", 64'(ok), 4);
    wr(A_CTRL, 0);
    wr(A_EVENT, 32'hFFFF_FFFF);

    // R9 start-sync
    wr(A_CTRL, 32'h1000_0000);
    time_i = 64'd0;
    wr(A_AL_LO0, 1000);
    wr(A_AL_LO0 + 4'd1, 0);
    wr(A_AL_LO0 + 4'd2, 100);
    wr(A_AL_LO0 + 4'd3, 0);
    wr(A_IVL0, 4);
    wr(A_CHCTL, 32'h0080_8041);
    ok = 1;
    for (int k = 0; k < 20; k++) begin
      if (pulse_o[0]) ok = 0;
      @(negedge clk);
    end
    chk("R9 held before alarm", ok, 1);
    time_i = 64'd200;
    ok = 1;
    for (int k = 0; k < 20; k++) begin
      if (pulse_o[0]) ok = 0;
      @(negedge clk);
    end
    chk("R9 alarm2 does not release", ok, 1);
    rd(A_EVENT, r); chk("R9 only alarm2 event", r, 32'h0002_0000);
    @(negedge clk); time_i = 64'd1000;
    @(negedge clk);
    meas(12);
    chk("R9 alarm1 fires at release", 64'(first_k[3]), 0);
    chk("R9 first pulse after release", 64'(first_k[0]), 5);
    chk("R9 period after release", 64'(second_k[0]), 10);
    wr(A_CHCTL, 32'h0080_8080);
    rd(A_EVENT, r); chk("R10 channel0 bit7 after sync", r, 32'h0003_0080);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule